// File: doc/BRIEF.md
# USB Host Transaction Retry Controller

This block runs one host transaction at a time and decides what happens after each attempt. Software writes a token code together with a buffer direction, a starting data toggle, a retry enable and a retry time budget. The controller asks the packet engine to launch the token. It then waits for the engine to report the attempt's outcome and acts on it. A handshake ends the attempt, a received data packet is checked against the expected toggle, and a NAK or a CRC error sends the same token out again while the time budget lasts.

The packet engine handles serialization, CRC and line coding. It sees this block only as a launch strobe with the token code, a buffer select and a toggle for the outgoing PID. It reports back one outcome event per attempt. When a transaction ends, the token code returns to idle and the status fields keep the result. For the three data-transfer token codes, a sticky completion flag is set and drives the interrupt if the interrupt is enabled.

Top module: `usb_xfer_retry_ctrl`

## Requirements
- R1: After reset the token code reads 000, tok_launch is low, tx_toggle is 0, all status fields are 0 and both cmp_flag and irq are low.
- R2: A cmd_valid with a nonzero cmd_token while idle produces exactly one tok_launch cycle, in the cycle after the command. During that cycle tok_code shows the token, buf_sel shows cmd_dir and tx_toggle shows cmd_toggle. A command with token 000, or any command while a transaction is in progress, is ignored.
- R3: An ACK outcome (ev_code 0) ends the transaction. It sets st_hs to 01, inverts the expected toggle and returns tok_code to 000.
- R4: A data outcome (ev_code 5) whose ev_rx_toggle matches the expected toggle pulses data_accept and ack_send for one cycle. It inverts the expected toggle and ends the transaction.
- R5: A data outcome with a mismatching toggle pulses data_discard and ack_send but not data_accept. It leaves the expected toggle unchanged, sets st_tog_err and ends the transaction.
- R6: A NAK outcome (ev_code 1) sets st_hs to 10. With retry enabled and budget left, it relaunches the same token in the next cycle with the same toggle.
- R7: A CRC error outcome (ev_code 3) sets st_crc. With retry enabled and budget left, it relaunches the same token in the next cycle.
- R8: A STALL outcome (ev_code 2, st_hs 11) or a disconnect outcome (ev_code 4, st_disc 1) always ends the transaction without a relaunch, even with retry enabled.
- R9: The retry budget is loaded from cmd_timer when the transaction starts. It drops by one on each bit_tick while a transaction is in progress and stops at zero. A NAK or CRC error that arrives when the budget is zero ends the transaction with st_timeout set.
- R10: With retry disabled, a NAK or CRC error ends the transaction at once with st_timeout left at 0.
- R11: cmp_flag is set when a transaction with token 001, 010 or 011 ends, and stays clear for any other token code. irq equals cmp_flag AND irq_en. irq_clr clears cmp_flag.
- R12: Outcome events that arrive while no attempt is awaiting an outcome change neither the status nor the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Software command strobe |
| cmd_token | input | 3 | Token code, 000 idle, 001 SETUP, 010 IN, 011 OUT |
| cmd_dir | input | 1 | Endpoint buffer select for the transaction |
| cmd_toggle | input | 1 | Starting data toggle |
| cmd_retry_en | input | 1 | Automatic retry enable |
| cmd_timer | input | TIMER_W | Retry budget in bit times |
| irq_en | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | Clears the completion flag |
| bit_tick | input | 1 | One pulse per bit time |
| ev_valid | input | 1 | Attempt outcome strobe from the packet engine |
| ev_code | input | 3 | Outcome: 0 ACK, 1 NAK, 2 STALL, 3 CRC error, 4 disconnect, 5 data received |
| ev_rx_toggle | input | 1 | Toggle of a received data PID |
| tok_launch | output | 1 | Launch request for the current token |
| tok_code | output | 3 | Current token code, 000 when idle |
| buf_sel | output | 1 | Buffer select for the transaction |
| tx_toggle | output | 1 | Expected toggle, used for the outgoing data PID |
| data_accept | output | 1 | Received data is kept |
| data_discard | output | 1 | Received data is dropped |
| ack_send | output | 1 | Request to send ACK after received data |
| st_hs | output | 2 | Handshake received: 00 none, 01 ACK, 10 NAK, 11 STALL |
| st_crc | output | 1 | A CRC error was seen |
| st_disc | output | 1 | Device disconnected |
| st_tog_err | output | 1 | Data toggle mismatch |
| st_timeout | output | 1 | Retry budget exhausted |
| cmp_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets the outcome decisions that are easy to get wrong. If STALL or disconnect were retried, a second launch pulse would appear. If the toggle were inverted on a mismatch, tx_toggle would be wrong on the next transaction. If the budget were compared off by one, NAKs arriving with one tick left or at zero would be treated the wrong way. It also checks that commands sent during a transaction, stray outcome events and non-transfer token codes leave no trace. A design that failed these would overwrite the token, corrupt the status or raise the completion flag when it should not.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        EV_ACK   = 3'd0,
        EV_NAK   = 3'd1,
        EV_STALL = 3'd2,
        EV_CRC   = 3'd3,
        EV_DISC  = 3'd4,
        EV_DATA  = 3'd5
    } ev_e;

    localparam logic [1:0] HS_NONE  = 2'b00;
    localparam logic [1:0] HS_ACK   = 2'b01;
    localparam logic [1:0] HS_NAK   = 2'b10;
    localparam logic [1:0] HS_STALL = 2'b11;

    typedef struct packed {
        logic [1:0] hs;
        logic       crc;
        logic       disc;
        logic       tog_err;
        logic       timeout;
    } status_t;

    function automatic logic is_xfer_token(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

endpackage

// File: rtl/xfer_retry_timer.sv
module xfer_retry_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TIMER_W-1:0] load_val,
    input  logic               run,
    input  logic               tick,
    output logic               expired
);

    logic [TIMER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R9: budget drops by exactly one per tick while running
    p_budget_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9: an exhausted budget stays at zero until reloaded
    p_budget_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/xfer_toggle_check.sv
module xfer_toggle_check (
    input  logic expected,
    input  logic rx_toggle,
    output logic match,
    output logic next_on_match
);

    assign match         = (expected == rx_toggle);
    assign next_on_match = ~expected;

endmodule

// File: rtl/xfer_cmp_irq.sv
module xfer_cmp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
    assign irq  = flag_q & en;

    // R11: the interrupt never fires without a pending flag
    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R11: a clear with no set leaves the flag low
    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/usb_xfer_retry_ctrl.sv
module usb_xfer_retry_ctrl
    import xfer_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_token,
    input  logic               cmd_dir,
    input  logic               cmd_toggle,
    input  logic               cmd_retry_en,
    input  logic [TIMER_W-1:0] cmd_timer,
    input  logic               irq_en,
    input  logic               irq_clr,
    input  logic               bit_tick,
    input  logic               ev_valid,
    input  logic [2:0]         ev_code,
    input  logic               ev_rx_toggle,
    output logic               tok_launch,
    output logic [2:0]         tok_code,
    output logic               buf_sel,
    output logic               tx_toggle,
    output logic               data_accept,
    output logic               data_discard,
    output logic               ack_send,
    output logic [1:0]         st_hs,
    output logic               st_crc,
    output logic               st_disc,
    output logic               st_tog_err,
    output logic               st_timeout,
    output logic               cmp_flag,
    output logic               irq
);

    typedef struct packed {
        state_e     st;
        logic [2:0] code;
        logic       dir;
        logic       tog;
        logic       ren;
        status_t    stat;
        logic       acc;
        logic       dis;
        logic       ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start, done, budget_gone, tog_match, tog_next;
    ev_e  ev;

    assign ev = ev_e'(ev_code);

    xfer_retry_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (cmd_timer),
        .run      (ctl_q.st != S_IDLE),
        .tick     (bit_tick),
        .expired  (budget_gone)
    );

    xfer_toggle_check u_tog (
        .expected      (ctl_q.tog),
        .rx_toggle     (ev_rx_toggle),
        .match         (tog_match),
        .next_on_match (tog_next)
    );

    xfer_cmp_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done && is_xfer_token(ctl_q.code)),
        .clr   (irq_clr),
        .en    (irq_en),
        .flag  (cmp_flag),
        .irq   (irq)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.acc = 1'b0;
        ctl_d.dis = 1'b0;
        ctl_d.ack = 1'b0;
        start     = 1'b0;
        done      = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (cmd_valid && (cmd_token != 3'b000)) begin
                    start      = 1'b1;
                    ctl_d.st   = S_LAUNCH;
                    ctl_d.code = cmd_token;
                    ctl_d.dir  = cmd_dir;
                    ctl_d.tog  = cmd_toggle;
                    ctl_d.ren  = cmd_retry_en;
                    ctl_d.stat = '0;
                end
            end
            S_LAUNCH: begin
                ctl_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (ev_valid) begin
                    case (ev)
                        EV_ACK: begin
                            ctl_d.stat.hs = HS_ACK;
                            ctl_d.tog     = ~ctl_q.tog;
                            done          = 1'b1;
                        end
                        EV_DATA: begin
                            ctl_d.ack = 1'b1;
                            if (tog_match) begin
                                ctl_d.acc = 1'b1;
                                ctl_d.tog = tog_next;
                            end else begin
                                ctl_d.dis          = 1'b1;
                                ctl_d.stat.tog_err = 1'b1;
                            end
                            done = 1'b1;
                        end
                        EV_NAK, EV_CRC: begin
                            if (ev == EV_NAK) ctl_d.stat.hs  = HS_NAK;
                            else              ctl_d.stat.crc = 1'b1;
                            if (ctl_q.ren && !budget_gone) begin
                                ctl_d.st = S_LAUNCH;
                            end else begin
                                ctl_d.stat.timeout = ctl_q.ren;
                                done               = 1'b1;
                            end
                        end
                        EV_STALL: begin
                            ctl_d.stat.hs = HS_STALL;
                            done          = 1'b1;
                        end
                        EV_DISC: begin
                            ctl_d.stat.disc = 1'b1;
                            done            = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
        if (done) begin
            ctl_d.st   = S_IDLE;
            ctl_d.code = 3'b000;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tok_launch   = (ctl_q.st == S_LAUNCH);
    assign tok_code     = ctl_q.code;
    assign buf_sel      = ctl_q.dir;
    assign tx_toggle    = ctl_q.tog;
    assign data_accept  = ctl_q.acc;
    assign data_discard = ctl_q.dis;
    assign ack_send     = ctl_q.ack;
    assign st_hs        = ctl_q.stat.hs;
    assign st_crc       = ctl_q.stat.crc;
    assign st_disc      = ctl_q.stat.disc;
    assign st_tog_err   = ctl_q.stat.tog_err;
    assign st_timeout   = ctl_q.stat.timeout;

    // R2: a launch request lasts one cycle
    p_launch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_launch |=> !tok_launch);

    // R1: no token is shown while idle
    p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_IDLE) |-> (tok_code == 3'b000));

    // R8: STALL and disconnect never lead to a relaunch
    p_no_retry_fatal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == S_WAIT) && ev_valid && ((ev_code == 3'd2) || (ev_code == 3'd4)))
        |=> (!tok_launch && (tok_code == 3'b000)));

    // R10: with retry disabled a NAK ends the transaction
    p_nak_no_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == S_WAIT) && ev_valid && (ev_code == 3'd1) && !ctl_q.ren)
        |=> (tok_code == 3'b000));

    // R5: data is never both kept and dropped
    p_accept_xor_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_accept && data_discard));

    // R4: an accept always comes with an ACK request
    p_accept_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_accept |-> ack_send);

endmodule

// File: tb/usb_xfer_retry_ctrl_tb.sv
module usb_xfer_retry_ctrl_tb;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_token = '0;
    logic          cmd_dir = 1'b0;
    logic          cmd_toggle = 1'b0;
    logic          cmd_retry_en = 1'b0;
    logic [TW-1:0] cmd_timer = '0;
    logic          irq_en = 1'b0;
    logic          irq_clr = 1'b0;
    logic          bit_tick = 1'b0;
    logic          ev_valid = 1'b0;
    logic [2:0]    ev_code = '0;
    logic          ev_rx_toggle = 1'b0;
    logic          tok_launch, buf_sel, tx_toggle, data_accept, data_discard, ack_send;
    logic [2:0]    tok_code;
    logic [1:0]    st_hs;
    logic          st_crc, st_disc, st_tog_err, st_timeout, cmp_flag, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    usb_xfer_retry_ctrl #(.TIMER_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_token(cmd_token),
        .cmd_dir(cmd_dir), .cmd_toggle(cmd_toggle), .cmd_retry_en(cmd_retry_en),
        .cmd_timer(cmd_timer), .irq_en(irq_en), .irq_clr(irq_clr), .bit_tick(bit_tick),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_rx_toggle(ev_rx_toggle),
        .tok_launch(tok_launch), .tok_code(tok_code), .buf_sel(buf_sel),
        .tx_toggle(tx_toggle), .data_accept(data_accept), .data_discard(data_discard),
        .ack_send(ack_send), .st_hs(st_hs), .st_crc(st_crc), .st_disc(st_disc),
        .st_tog_err(st_tog_err), .st_timeout(st_timeout), .cmp_flag(cmp_flag), .irq(irq)
    );

    typedef struct packed {
        logic [2:0] tok;
        logic       tog;
        logic       ren;
        logic [2:0] ev;
        logic       rxt;
        logic       rel;
        logic [1:0] hs;
        logic       etog;
        logic       cmp;
    } vec_t;

    // tok tog ren ev rxt | relaunch hs toggle-after cmp
    localparam vec_t VEC [10] = '{
        '{3'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1},
        '{3'd1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1},
        '{3'd2, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1},
        '{3'd2, 1'b1, 1'b0, 3'd5, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1},
        '{3'd3, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0},
        '{3'd2, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},
        '{3'd3, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1},
        '{3'd3, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1},
        '{3'd4, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0},
        '{3'd2, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive a command; returns at the negedge where the launch cycle is visible
    task automatic send_cmd(input logic [2:0] tok, input logic dir, input logic tog,
                            input logic ren, input logic [TW-1:0] tmr);
        cmd_valid = 1'b1; cmd_token = tok; cmd_dir = dir;
        cmd_toggle = tog; cmd_retry_en = ren; cmd_timer = tmr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // drive one outcome; returns at the negedge where its effect is visible
    task automatic send_ev(input logic [2:0] code, input logic rxt);
        ev_valid = 1'b1; ev_code = code; ev_rx_toggle = rxt;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic clear_flag();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tok_code", tok_code, 0);
        chk("R1 launch", tok_launch, 0);
        chk("R1 toggle", tx_toggle, 0);
        chk("R1 status", {st_hs, st_crc, st_disc, st_tog_err, st_timeout}, 0);
        chk("R1 irq", {cmp_flag, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            clear_flag();
            send_cmd(VEC[i].tok, 1'b1, VEC[i].tog, VEC[i].ren, 16'd8);
            chk("R2 launch", tok_launch, 1);
            chk("R2 code", tok_code, VEC[i].tok);
            chk("R2 buf_sel", buf_sel, 1);
            chk("R2 toggle", tx_toggle, VEC[i].tog);
            @(negedge clk);
            chk("R2 single launch", tok_launch, 0);
            send_ev(VEC[i].ev, VEC[i].rxt);
            chk("R6 R7 R8 relaunch", tok_launch, VEC[i].rel);
            chk("R3 R6 R8 hs", st_hs, VEC[i].hs);
            chk("R3 R4 R5 toggle", tx_toggle, VEC[i].etog);
            chk("R11 cmp", cmp_flag, VEC[i].cmp);
            chk("R3 code after", tok_code, VEC[i].rel ? VEC[i].tok : 3'd0);
            if (VEC[i].rel) begin
                chk("R7 crc", st_crc, VEC[i].ev == 3'd3);
                @(negedge clk);
                send_ev(3'd0, 1'b0);
                chk("R6 retry completes", tok_code, 0);
            end
            if (VEC[i].ev == 3'd4) chk("R8 disc", st_disc, 1);
            chk("R10 no timeout", st_timeout, 0);
        end

        // R4 matching data pulses
        clear_flag();
        send_cmd(3'd2, 1'b0, 1'b1, 1'b0, 16'd8);
        @(negedge clk);
        send_ev(3'd5, 1'b1);
        chk("R4 accept/discard/ack", {data_accept, data_discard, ack_send}, 3'b101);
        chk("R4 toggle", tx_toggle, 0);
        @(negedge clk);
        chk("R4 pulse width", {data_accept, ack_send}, 2'b00);

        // R5 mismatch pulses
        send_cmd(3'd2, 1'b0, 1'b0, 1'b0, 16'd8);
        @(negedge clk);
        send_ev(3'd5, 1'b1);
        chk("R5 accept/discard/ack", {data_accept, data_discard, ack_send}, 3'b011);
        chk("R5 toggle kept", tx_toggle, 0);
        chk("R5 tog_err", st_tog_err, 1);

        // R12 stray event while idle
        send_ev(3'd0, 1'b0);
        chk("R12 toggle", tx_toggle, 0);
        chk("R12 status", {st_hs, st_tog_err}, 3'b001);

        // R2 command with token 000 ignored
        send_cmd(3'd0, 1'b1, 1'b1, 1'b0, 16'd8);
        chk("R2 zero token launch", tok_launch, 0);
        chk("R2 zero token code", tok_code, 0);

        // R2 command while busy ignored
        send_cmd(3'd3, 1'b0, 1'b0, 1'b0, 16'd8);
        @(negedge clk);
        send_cmd(3'd2, 1'b1, 1'b1, 1'b0, 16'd8);
        chk("R2 busy launch", tok_launch, 0);
        chk("R2 busy code", {tok_code, buf_sel, tx_toggle}, {3'd3, 1'b0, 1'b0});
        send_ev(3'd0, 1'b0);

        // R9 budget of 3 exhausted by 3 ticks
        send_cmd(3'd3, 1'b0, 1'b0, 1'b1, 16'd3);
        @(negedge clk);
        bit_tick = 1'b1;
        repeat (3) @(negedge clk);
        bit_tick = 1'b0;
        send_ev(3'd1, 1'b0);
        chk("R9 expired no relaunch", tok_launch, 0);
        chk("R9 timeout", {st_timeout, st_hs, tok_code}, {1'b1, 2'b10, 3'd0});

        // R9 budget of 4 with 3 ticks still retries
        send_cmd(3'd3, 1'b0, 1'b0, 1'b1, 16'd4);
        @(negedge clk);
        bit_tick = 1'b1;
        repeat (3) @(negedge clk);
        bit_tick = 1'b0;
        send_ev(3'd3, 1'b0);
        chk("R9 one left relaunch", tok_launch, 1);
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        send_ev(3'd3, 1'b0);
        chk("R9 now expired", {tok_launch, st_timeout, st_crc}, 3'b011);

        // R10 CRC error without retry
        send_cmd(3'd1, 1'b0, 1'b0, 1'b0, 16'd8);
        @(negedge clk);
        send_ev(3'd3, 1'b0);
        chk("R10 crc ends", {tok_launch, tok_code, st_timeout}, 5'b0);

        // R11 interrupt gating and clear
        chk("R11 flag gated", {cmp_flag, irq}, 2'b10);
        irq_en = 1'b1;
        #1;
        chk("R11 irq enabled", irq, 1);
        clear_flag();
        chk("R11 cleared", {cmp_flag, irq}, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule